// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts where a subroutine return will go by remembering the call history. When the fetch logic sees an instruction marked as a call, it raises a push strobe and supplies the call's PC. The block stores the address of the instruction that follows the call site, which is the call PC plus the instruction size. When the fetch logic sees an instruction marked as a return, it raises a pop strobe. In that same cycle the block offers the most recent stored address as the predicted next PC, and it removes that entry.

The storage is a circular buffer with a top pointer and an occupancy count that cannot exceed the depth. A call chain deeper than the buffer overwrites the oldest entries. The innermost returns are still predicted correctly, and only the outermost ones are lost. A pop on an empty stack gives no valid prediction and changes nothing. A push and a pop in the same cycle replace the top entry. Deciding which instructions are calls or returns, and repairing the stack after a misprediction, are both left to the surrounding logic.

Top module: `ret_addr_stack`

## Requirements
- R1: When `call_i` is high and `ret_i` is low, the value `call_pc_i + INST_BYTES` becomes the top entry. From the next cycle it appears on `pred_target_o`.
- R2: When `ret_i` is high and the stack holds at least one entry, `pred_valid_o` is high in that cycle and `pred_target_o` equals the top entry. That entry is then removed.
- R3: Entries are predicted in the reverse order of their pushes. Nested calls A, B, C, D give return predictions D, C, B, A.
- R4: A push when DEPTH entries are held overwrites the oldest entry, and the count stays at DEPTH. After DEPTH+1 pushes, DEPTH pops return the newest DEPTH addresses, newest first, and the next pop is not valid.
- R5: A pop on an empty stack drives `pred_valid_o` low and leaves the stack unchanged. A later push followed by a pop returns exactly the pushed address.
- R6: When `call_i` and `ret_i` are both high on a non-empty stack, the old top is predicted with `pred_valid_o` high. The top is then replaced by the new return address, and the number of entries does not change.
- R7: When `call_i` and `ret_i` are both high on an empty stack, `pred_valid_o` is low and the cycle acts as a push.
- R8: A synchronous reset (`rst` high at a clock edge) empties the stack, so the next pop is not valid.
- R9: `pred_valid_o` is low in every cycle in which `ret_i` is low.
- R10: With both strobes low, the stack is unchanged whatever value `call_pc_i` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, empties the stack |
| call_i | input | 1 | Call-type instruction seen: push return address |
| call_pc_i | input | AW (32) | PC of the call instruction |
| ret_i | input | 1 | Return-type instruction seen: pop and predict |
| pred_target_o | output | AW (32) | Current top entry, the predicted return target |
| pred_valid_o | output | 1 | Prediction is valid (pop on a non-empty stack) |

## Verification
A corrupted top pointer or a wrong occupancy count shows up at the ports on the next return. That return either predicts the wrong address or raises or drops the valid flag against the reference model. An error in the count on overflow or underflow can stay hidden until the stack drains, and then it shows as a stray valid prediction or a missing one. The bench therefore empties the stack completely after the deep sequences. It compares the outputs in every cycle against a queue-based model, so any fault is reported on the first return that exposes it.

// File: rtl/ras_pkg.sv
package ras_pkg;

   typedef enum logic [1:0] {
      RAS_IDLE = 2'd0,
      RAS_PUSH = 2'd1,
      RAS_POP  = 2'd2,
      RAS_SWAP = 2'd3
   } ras_op_e;

   function automatic ras_op_e ras_decode(input logic push, input logic pop, input logic empty);
      ras_op_e op;
      if (push && pop && !empty)  op = RAS_SWAP;
      else if (push)              op = RAS_PUSH;
      else if (pop && !empty)     op = RAS_POP;
      else                        op = RAS_IDLE;
      return op;
   endfunction

endpackage

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl
   import ras_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          push,
   input  logic          pop,
   output logic          empty,
   output logic          wr_en,
   output logic [PW-1:0] wr_idx,
   output logic [PW-1:0] top_idx,
   output logic [CW-1:0] occ
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);

   logic [PW-1:0] top_q, top_d, top_inc, top_dec;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          full;
   ras_op_e       op;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign top_inc = top_q + PW'(1);
         assign top_dec = top_q - PW'(1);
      end else begin : g_mod_wrap
         assign top_inc = (top_q == LAST_IDX) ? '0 : top_q + PW'(1);
         assign top_dec = (top_q == '0) ? LAST_IDX : top_q - PW'(1);
      end
   endgenerate

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == FULL_CNT);
   assign op    = ras_decode(push, pop, empty);

   always_comb begin
      top_d  = top_q;
      cnt_d  = cnt_q;
      wr_en  = 1'b0;
      wr_idx = top_q;
      unique case (op)
         RAS_PUSH: begin
            wr_en  = 1'b1;
            wr_idx = top_inc;
            top_d  = top_inc;
            if (!full) cnt_d = cnt_q + CW'(1);
         end
         RAS_POP: begin
            top_d = top_dec;
            cnt_d = cnt_q - CW'(1);
         end
         RAS_SWAP: begin
            wr_en  = 1'b1;
            wr_idx = top_q;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         top_q <= '0;
         cnt_q <= '0;
      end else begin
         top_q <= top_d;
         cnt_q <= cnt_d;
      end
   end

   assign top_idx = top_q;
   assign occ     = cnt_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
   parameter int AW    = 32,
   parameter int DEPTH = 8,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [PW-1:0] wr_idx,
   input  logic [AW-1:0] wr_data,
   input  logic [PW-1:0] rd_idx,
   output logic [AW-1:0] rd_data
);

   logic [AW-1:0] slot_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk) begin
         if (wr_en && (wr_idx == PW'(gi))) slot_q[gi] <= wr_data;
      end
   end

   assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
   parameter int AW         = 32,
   parameter int DEPTH      = 8,
   parameter int INST_BYTES = 4,
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          call_i,
   input  logic [AW-1:0] call_pc_i,
   input  logic          ret_i,
   output logic [AW-1:0] pred_target_o,
   output logic          pred_valid_o
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("ret_addr_stack: DEPTH must be at least 2");
   end
   if (AW < 2) begin : g_bad_aw
      $error("ret_addr_stack: AW must be at least 2");
   end
   if (INST_BYTES < 1) begin : g_bad_step
      $error("ret_addr_stack: INST_BYTES must be positive");
   end

   localparam logic [AW-1:0] STEP = AW'(INST_BYTES);

   logic          empty;
   logic          wr_en;
   logic [PW-1:0] wr_idx;
   logic [PW-1:0] top_idx;
   logic [CW-1:0] occ;
   logic [AW-1:0] ret_addr;

   assign ret_addr = call_pc_i + STEP;

   ras_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .push    (call_i),
      .pop     (ret_i),
      .empty   (empty),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .top_idx (top_idx),
      .occ     (occ)
   );

   ras_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (ret_addr),
      .rd_idx  (top_idx),
      .rd_data (pred_target_o)
   );

   assign pred_valid_o = ret_i & ~empty;

endmodule

// File: rtl/ras_chk.sv
module ras_chk #(
   parameter int AW         = 32,
   parameter int DEPTH      = 8,
   parameter int INST_BYTES = 4,
   localparam int CW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst,
   input logic          call_i,
   input logic [AW-1:0] call_pc_i,
   input logic          ret_i,
   input logic [AW-1:0] pred_target_o,
   input logic          pred_valid_o,
   input logic [CW-1:0] occ
);

   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [AW-1:0] STEP     = AW'(INST_BYTES);

   assert_push_visible_R1: assert property (@(posedge clk) disable iff (rst)
      (call_i && !ret_i) |=> (pred_target_o == $past(call_pc_i) + STEP));

   assert_pop_valid_R2: assert property (@(posedge clk) disable iff (rst)
      (ret_i && occ != '0) |-> pred_valid_o);

   assert_full_saturates_R4: assert property (@(posedge clk) disable iff (rst)
      (call_i && !ret_i && occ == FULL_CNT) |=> (occ == FULL_CNT));

   assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
      occ <= FULL_CNT);

   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
      (ret_i && !call_i && occ == '0) |-> (!pred_valid_o ##1 occ == '0));

   assert_swap_keeps_count_R6: assert property (@(posedge clk) disable iff (rst)
      (call_i && ret_i && occ != '0) |=> $stable(occ));

   assert_swap_empty_push_R7: assert property (@(posedge clk) disable iff (rst)
      (call_i && ret_i && occ == '0) |-> (!pred_valid_o ##1 occ == CW'(1)));

   assert_valid_needs_ret_R9: assert property (@(posedge clk) disable iff (rst)
      pred_valid_o |-> ret_i);

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
      (!call_i && !ret_i) |=> ($stable(occ) && $stable(pred_target_o)));

endmodule

bind ret_addr_stack ras_chk #(
   .AW(AW), .DEPTH(DEPTH), .INST_BYTES(INST_BYTES)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .call_i        (call_i),
   .call_pc_i     (call_pc_i),
   .ret_i         (ret_i),
   .pred_target_o (pred_target_o),
   .pred_valid_o  (pred_valid_o),
   .occ           (occ)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;

   localparam int AW    = 32;
   localparam int DEPTH = 8;
   localparam int STEP  = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          call_i;
   logic [AW-1:0] call_pc_i;
   logic          ret_i;
   logic [AW-1:0] pred_target_o;
   logic          pred_valid_o;

   int unsigned   model_q[$];
   int            n_checks = 0;
   int            n_bad    = 0;
   bit            finished = 0;
   int unsigned   lcg = 32'h1234_5678;

   always #5 clk = ~clk;

   ret_addr_stack #(.AW(AW), .DEPTH(DEPTH), .INST_BYTES(STEP)) u_dut (
      .clk(clk), .rst(rst), .call_i(call_i), .call_pc_i(call_pc_i),
      .ret_i(ret_i), .pred_target_o(pred_target_o), .pred_valid_o(pred_valid_o)
   );

   task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One clock cycle: drive at negedge, compare outputs, then advance the model at posedge.
   task automatic step(input logic c, input logic [AW-1:0] pc, input logic r, input logic rs, input string tag);
      bit          ev;
      int unsigned et;
      @(negedge clk);
      call_i = c; call_pc_i = pc; ret_i = r; rst = rs;
      #2;
      ev = !rs && r && (model_q.size() > 0);
      et = (model_q.size() > 0) ? model_q[$] : 0;
      if (!rs) begin
         check({tag, " valid"}, {31'd0, pred_valid_o}, {31'd0, ev});
         if (ev) check({tag, " target"}, pred_target_o, et);
      end
      @(posedge clk);
      if (rs) model_q.delete();
      else if (c && r && model_q.size() > 0) model_q[$] = pc + STEP;
      else if (c) begin
         model_q.push_back(pc + STEP);
         if (model_q.size() > DEPTH) void'(model_q.pop_front());
      end else if (r && model_q.size() > 0) void'(model_q.pop_back());
   endtask

   initial begin
      call_i = 0; call_pc_i = '0; ret_i = 0; rst = 1;
      step(0, 0, 0, 1, "R8");
      step(0, 0, 0, 1, "R8");
      step(0, 0, 1, 0, "R8 reset empty");
      // R9, R10: idle with noise on the PC
      step(1, 32'h0000_1000, 0, 0, "R1");
      for (int i = 0; i < 4; i++) step(0, 32'hDEAD_0000 + i, 0, 0, "R10");
      step(0, 0, 1, 0, "R10 after idle");
      // R3: nested A B C D
      step(1, 32'h0000_0A00, 0, 0, "R1");
      step(1, 32'h0000_0B00, 0, 0, "R1");
      step(1, 32'h0000_0C00, 0, 0, "R1");
      step(1, 32'h0000_0D00, 0, 0, "R1");
      for (int i = 0; i < 4; i++) step(0, 0, 1, 0, "R3");
      // R5: underflow
      step(0, 0, 1, 0, "R5");
      step(0, 0, 1, 0, "R5");
      step(1, 32'h0000_5550, 0, 0, "R5");
      step(0, 0, 1, 0, "R5 push after underflow");
      step(0, 0, 1, 0, "R5");
      // R4: overflow
      for (int i = 0; i < DEPTH + 3; i++) step(1, 32'h0010_0000 + 32'(i) * 16, 0, 0, "R4");
      for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 1, 0, "R4");
      // R6: simultaneous on non-empty
      step(1, 32'h0000_6000, 0, 0, "R6");
      step(1, 32'h0000_6100, 0, 0, "R6");
      step(1, 32'h0000_6200, 1, 0, "R6 swap");
      step(0, 0, 1, 0, "R6");
      step(0, 0, 1, 0, "R6");
      step(0, 0, 1, 0, "R6");
      // R7: simultaneous on empty
      step(1, 32'h0000_7000, 1, 0, "R7");
      step(0, 0, 1, 0, "R7");
      step(0, 0, 1, 0, "R7");
      // R8: reset from full
      for (int i = 0; i < DEPTH; i++) step(1, 32'h0000_8000 + 32'(i) * 8, 0, 0, "R8");
      step(0, 0, 0, 1, "R8");
      step(0, 0, 1, 0, "R8 after reset");
      // mixed pseudo-random traffic
      for (int i = 0; i < 400; i++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         step(lcg[20], {lcg[31:4], 4'h0}, lcg[23] | lcg[25], 0, "R3 mixed");
      end
      for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 1, 0, "R3 drain");
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

   initial begin
      #200000;
      if (!finished) begin
         finished = 1;
         n_checks++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_checks, n_bad);
         $finish;
      end
   end

endmodule